// File: doc/BRIEF.md
# DPCD Burst Transfer Sequencer

This block carries out one read or write of the sink's configuration register space over the auxiliary channel. A request names a 20-bit register address, a byte count and a direction. The block splits the request into chunks of at most `CHUNK` bytes and issues one native transaction per chunk on a lower-level transaction port. That port uses a start pulse, a pending flag that must drop, and a reply pulse that carries an error flag and a status code. The block moves bytes between its chunk buffer and a caller-side byte port, which is indexed by the byte's position inside the request.

Each chunk is tried up to `MAX_TRY` times. An attempt fails if the pending flag is not released within the acknowledge window, if no reply arrives within the reply window, or if the reply reports a problem. Both windows are counted in ticks from a parameterised prescaler, so a bench can use short windows and a chip can use millisecond windows. When every attempt on a chunk fails, the whole request ends with an error and the remaining chunks are not issued. A request with zero length ends at once with success.

Top module: `dpcd_burst_seq`

## Requirements
- R1: A request of N bytes is issued as chunks of min(remaining, CHUNK) bytes, and each chunk's `tx_len_m1` equals its length minus one (CHUNK=16, so a full chunk shows 15).
- R2: Each chunk's address is the request address plus the bytes already completed, presented as `tx_addr_lo` = bits 7:0, `tx_addr_mid` = bits 15:8, `tx_addr_hi` = bits 19:16. The same address is repeated on every retry of that chunk.
- R3: A chunk is attempted at most MAX_TRY (10) times. After the last failure `done` pulses with `done_err`=1 and no further `tx_start` follows for that request.
- R4: `tx_cmd` is 4'b1000 for a native write and 4'b1001 for a native read. Bit 3 is 1 on every issued transaction.
- R5: The chunk buffer is cleared at the start of every attempt. For writes, byte k of the chunk (request index base+k, read from the caller port) is on `tx_wdata[8k+7:8k]` when `tx_start` is high, and lanes at or above the chunk length are zero.
- R6: An attempt fails when `tx_pend` stays high for ACK_TICKS ticks, when no `tx_reply` arrives within RPLY_TICKS ticks after the pending flag drops, when `tx_rerr` is 1 at the reply, or when `tx_rstat` is nonzero at the reply.
- R7: For reads, bytes go to the caller (`cb_wr_en`, `cb_idx` = request byte index, `cb_wdata`) only after a successful attempt and only from that attempt's data. A failed attempt writes nothing to the caller.
- R8: A request with `req_len`=0 gives `done`=1 with `done_err`=0 in the cycle after acceptance, and no `tx_start`.
- R9: `done` is a one-cycle pulse, after which `busy` is 0. `done_err` is 0 for a request whose chunks all succeeded.
- R10: The attempt count starts again for each chunk, so a chunk that succeeds on its last allowed attempt lets the next chunk have its own full set of attempts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is 0 |
| req_write | input | 1 | 1 = write to sink, 0 = read from sink |
| req_addr | input | 20 | Start register address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Valid with `done`: request aborted |
| cb_rd_en | output | 1 | Caller byte fetch (writes) |
| cb_wr_en | output | 1 | Caller byte store (reads) |
| cb_idx | output | LEN_W | Byte index within the request |
| cb_rdata | input | 8 | Caller byte for `cb_idx`, same cycle |
| cb_wdata | output | 8 | Byte stored to the caller |
| tx_start | output | 1 | Starts one transaction attempt |
| tx_cmd | output | 4 | Command field |
| tx_addr_lo | output | 8 | Address bits 7:0 |
| tx_addr_mid | output | 8 | Address bits 15:8 |
| tx_addr_hi | output | 4 | Address bits 19:16 |
| tx_len_m1 | output | $clog2(CHUNK) | Chunk length minus one |
| tx_wdata | output | CHUNK*8 | Chunk buffer contents |
| tx_pend | input | 1 | Start not yet taken by the lower layer |
| tx_reply | input | 1 | Reply pulse |
| tx_rerr | input | 1 | Reply error flag |
| tx_rstat | input | 4 | Reply status code |
| tx_rd_we | input | 1 | Returned read byte strobe |
| tx_rd_idx | input | $clog2(CHUNK) | Lane of returned byte |
| tx_rd_data | input | 8 | Returned read byte |

## Verification
Requests of zero length, of less than one chunk, of exactly one chunk and of several chunks across a 64 KiB address boundary separate errors in the chunk count, the length field and the address advance. Scripted responder faults cover each of the four ways an attempt can fail. In these runs the responder also returns corrupted bytes on failed reads, so a copy made too early shows up as wrong caller data. A write that follows a full read tells apart a buffer that is cleared on each attempt from one that is not. Chunks that succeed on the tenth attempt are run against a chunk that fails all ten, which marks the retry limit and its reset at each chunk.

// File: rtl/dpcd_seq_pkg.sv
package dpcd_seq_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_CLR, S_LOAD, S_ISSUE, S_WACK, S_WRPLY, S_FAIL, S_COPY, S_ADV, S_FIN
   } seq_state_t;

   localparam logic [3:0] CMD_NATIVE_WR = 4'b1000;
   localparam logic [3:0] CMD_NATIVE_RD = 4'b1001;
endpackage

// File: rtl/dpcd_tick_timer.sv
module dpcd_tick_timer #(
   parameter int TICK_DIV = 1,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic             tick;
   logic [CNT_W-1:0] tcnt;

   generate
      if (TICK_DIV <= 1) begin : g_nodiv
         assign tick = ~restart;
      end else begin : g_div
         localparam int PW = $clog2(TICK_DIV);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre <= '0;
            else if (restart || pre == PW'(TICK_DIV - 1))
               pre <= '0;
            else
               pre <= pre + PW'(1);
         end
         assign tick = !restart && (pre == PW'(TICK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tcnt <= '0;
      else if (restart)
         tcnt <= '0;
      else if (tick && !expired)
         tcnt <= tcnt + CNT_W'(1);
   end

   assign expired = (tcnt >= limit);
endmodule

// File: rtl/dpcd_chunk_buf.sv
module dpcd_chunk_buf #(
   parameter int CHUNK = 16,
   localparam int IW   = $clog2(CHUNK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               ld_we,
   input  logic [IW-1:0]      ld_idx,
   input  logic [7:0]         ld_data,
   input  logic               rx_we,
   input  logic [IW-1:0]      rx_idx,
   input  logic [7:0]         rx_data,
   input  logic [IW-1:0]      rd_idx,
   output logic [7:0]         rd_data,
   output logic [CHUNK*8-1:0] flat
);
   generate
      for (genvar g = 0; g < CHUNK; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flat[g*8 +: 8] <= '0;
            else if (clr)
               flat[g*8 +: 8] <= '0;
            else if (ld_we && ld_idx == IW'(g))
               flat[g*8 +: 8] <= ld_data;
            else if (rx_we && rx_idx == IW'(g))
               flat[g*8 +: 8] <= rx_data;
         end
      end
   endgenerate

   assign rd_data = flat[rd_idx*8 +: 8];
endmodule

// File: rtl/dpcd_burst_seq.sv
module dpcd_burst_seq
   import dpcd_seq_pkg::*;
#(
   parameter int LEN_W      = 8,
   parameter int CHUNK      = 16,
   parameter int MAX_TRY    = 10,
   parameter int TICK_DIV   = 200000,
   parameter int ACK_TICKS  = 20,
   parameter int RPLY_TICKS = 10,
   localparam int CW        = $clog2(CHUNK)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [19:0]        req_addr,
   input  logic [LEN_W-1:0]   req_len,
   output logic               busy,
   output logic               done,
   output logic               done_err,
   output logic               cb_rd_en,
   output logic               cb_wr_en,
   output logic [LEN_W-1:0]   cb_idx,
   input  logic [7:0]         cb_rdata,
   output logic [7:0]         cb_wdata,
   output logic               tx_start,
   output logic [3:0]         tx_cmd,
   output logic [7:0]         tx_addr_lo,
   output logic [7:0]         tx_addr_mid,
   output logic [3:0]         tx_addr_hi,
   output logic [CW-1:0]      tx_len_m1,
   output logic [CHUNK*8-1:0] tx_wdata,
   input  logic               tx_pend,
   input  logic               tx_reply,
   input  logic               tx_rerr,
   input  logic [3:0]         tx_rstat,
   input  logic               tx_rd_we,
   input  logic [CW-1:0]      tx_rd_idx,
   input  logic [7:0]         tx_rd_data
);
   localparam int CLW   = CW + 1;
   localparam int TRY_W = $clog2(MAX_TRY + 1);
   localparam int TMAX  = (ACK_TICKS > RPLY_TICKS) ? ACK_TICKS : RPLY_TICKS;
   localparam int TW    = $clog2(TMAX + 1);

   generate
      if (CHUNK < 2 || (CHUNK & (CHUNK - 1)) != 0) begin : g_bad_chunk
         $error("CHUNK must be a power of two of at least 2");
      end
      if (LEN_W < CLW) begin : g_bad_len
         $error("LEN_W too narrow for CHUNK");
      end
      if (MAX_TRY < 1 || ACK_TICKS < 1 || RPLY_TICKS < 1) begin : g_bad_cnt
         $error("MAX_TRY and window lengths must be positive");
      end
   endgenerate

   seq_state_t        state;
   logic [19:0]       addr_r;
   logic [LEN_W-1:0]  remain;
   logic [LEN_W-1:0]  ptr;
   logic              wr_r;
   logic              err_r;
   logic [TRY_W-1:0]  tries;
   logic [CLW-1:0]    k;
   logic [CLW-1:0]    chunk_len;
   logic              last_k;
   logic              expired;
   logic              t_restart;
   logic [TW-1:0]     t_limit;
   logic              bad_reply;

   assign chunk_len = (remain >= LEN_W'(CHUNK)) ? CLW'(CHUNK) : CLW'(remain);
   assign last_k    = (k == chunk_len - CLW'(1));
   assign bad_reply = tx_rerr || (tx_rstat != 4'h0);

   assign t_restart = (state == S_ISSUE) || (state == S_WACK && !tx_pend);
   assign t_limit   = (state == S_WRPLY) ? TW'(RPLY_TICKS) : TW'(ACK_TICKS);

   dpcd_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (t_restart),
      .limit   (t_limit),
      .expired (expired)
   );

   dpcd_chunk_buf #(.CHUNK(CHUNK)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (state == S_CLR),
      .ld_we   (state == S_LOAD),
      .ld_idx  (k[CW-1:0]),
      .ld_data (cb_rdata),
      .rx_we   (tx_rd_we && state == S_WRPLY),
      .rx_idx  (tx_rd_idx),
      .rx_data (tx_rd_data),
      .rd_idx  (k[CW-1:0]),
      .rd_data (cb_wdata),
      .flat    (tx_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         addr_r <= '0;
         remain <= '0;
         ptr    <= '0;
         wr_r   <= 1'b0;
         err_r  <= 1'b0;
         tries  <= '0;
         k      <= '0;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               addr_r <= req_addr;
               remain <= req_len;
               ptr    <= '0;
               wr_r   <= req_write;
               err_r  <= 1'b0;
               tries  <= '0;
               state  <= (req_len == '0) ? S_FIN : S_CLR;
            end
            S_CLR: begin
               k     <= '0;
               state <= wr_r ? S_LOAD : S_ISSUE;
            end
            S_LOAD: begin
               k <= k + CLW'(1);
               if (last_k) state <= S_ISSUE;
            end
            S_ISSUE: state <= S_WACK;
            S_WACK: begin
               if (!tx_pend)     state <= S_WRPLY;
               else if (expired) state <= S_FAIL;
            end
            S_WRPLY: begin
               if (tx_reply) begin
                  k     <= '0;
                  state <= bad_reply ? S_FAIL : (wr_r ? S_ADV : S_COPY);
               end else if (expired) begin
                  state <= S_FAIL;
               end
            end
            S_FAIL: begin
               if (tries == TRY_W'(MAX_TRY - 1)) begin
                  err_r <= 1'b1;
                  state <= S_FIN;
               end else begin
                  tries <= tries + TRY_W'(1);
                  state <= S_CLR;
               end
            end
            S_COPY: begin
               k <= k + CLW'(1);
               if (last_k) state <= S_ADV;
            end
            S_ADV: begin
               addr_r <= addr_r + 20'(chunk_len);
               ptr    <= ptr + LEN_W'(chunk_len);
               remain <= remain - LEN_W'(chunk_len);
               tries  <= '0;
               state  <= (remain == LEN_W'(chunk_len)) ? S_FIN : S_CLR;
            end
            S_FIN:   state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy        = (state != S_IDLE);
   assign done        = (state == S_FIN);
   assign done_err    = (state == S_FIN) && err_r;
   assign cb_rd_en    = (state == S_LOAD);
   assign cb_wr_en    = (state == S_COPY);
   assign cb_idx      = ptr + LEN_W'(k);
   assign tx_start    = (state == S_ISSUE);
   assign tx_cmd      = wr_r ? CMD_NATIVE_WR : CMD_NATIVE_RD;
   assign tx_addr_lo  = addr_r[7:0];
   assign tx_addr_mid = addr_r[15:8];
   assign tx_addr_hi  = addr_r[19:16];
   assign tx_len_m1   = CW'(chunk_len - CLW'(1));
endmodule

// File: rtl/dpcd_burst_seq_chk.sv
module dpcd_burst_seq_chk #(
   parameter int LEN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [LEN_W-1:0] req_len,
   input logic             busy,
   input logic             done,
   input logic             done_err,
   input logic             cb_rd_en,
   input logic             cb_wr_en,
   input logic             tx_start,
   input logic [3:0]       tx_cmd
);
   logic mode_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_wr <= 1'b0;
      else if (req_valid && !busy)
         mode_wr <= req_write;
   end

   // R4: command code follows the accepted direction
   a_r4_native_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> (tx_cmd == (mode_wr ? 4'b1000 : 4'b1001)));

   // R7: caller stores only happen on reads
   a_r7_store_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      cb_wr_en |-> !mode_wr);

   // R5: caller fetches only happen on writes
   a_r5_fetch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      cb_rd_en |-> mode_wr);

   // R8: zero-length request completes next cycle without error
   a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_len == '0) |=> (done && !done_err));

   // R9: done is a single-cycle pulse and the block goes idle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R3: nothing is issued while idle
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!tx_start && !cb_rd_en && !cb_wr_en));

   // R2: a start lasts one cycle
   a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);
endmodule

bind dpcd_burst_seq dpcd_burst_seq_chk #(.LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_len   (req_len),
   .busy      (busy),
   .done      (done),
   .done_err  (done_err),
   .cb_rd_en  (cb_rd_en),
   .cb_wr_en  (cb_wr_en),
   .tx_start  (tx_start),
   .tx_cmd    (tx_cmd)
);

// File: tb/tb_dpcd_burst_seq.sv
`timescale 1ns/1ps
module tb_dpcd_burst_seq;
   localparam int LEN_W = 8;
   localparam int CHUNK = 16;
   localparam int CW    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic busy, done, done_err, cb_rd_en, cb_wr_en, tx_start;
   logic [LEN_W-1:0] cb_idx;
   logic [7:0] cb_rdata, cb_wdata;
   logic [3:0] tx_cmd, tx_addr_hi, tx_rstat = 4'h0;
   logic [7:0] tx_addr_lo, tx_addr_mid, tx_rd_data = '0;
   logic [CW-1:0] tx_len_m1, tx_rd_idx = '0;
   logic [CHUNK*8-1:0] tx_wdata;
   logic tx_pend = 1'b0, tx_reply = 1'b0, tx_rerr = 1'b0, tx_rd_we = 1'b0;

   always #2.5 clk = ~clk;

   assign cb_rdata = 8'(cb_idx * 13 + 5);

   dpcd_burst_seq #(.LEN_W(LEN_W), .CHUNK(CHUNK), .MAX_TRY(10), .TICK_DIV(4),
                    .ACK_TICKS(20), .RPLY_TICKS(10)) dut (.*);

   int checks = 0, fails = 0;
   int script[$];
   int rsp_q[$];
   int e_addr[$], e_cmd[$], e_lm1[$], e_idx[$], e_dat[$];
   logic [CHUNK*8-1:0] e_wd[$];
   bit exp_err = 0;
   bit done_seen = 0;

   function automatic logic [7:0] rb(input int a);
      return 8'((a & 32'hFFFFF) * 7 + 3);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // responder and per-clock comparison against the model
   int r_cnt = 0, r_mode = 0, r_k = 0, r_lm1 = 0, r_addr = 0;
   bit r_act = 0, r_rd = 0;
   always @(negedge clk) begin
      tx_reply = 1'b0;
      tx_rd_we = 1'b0;
      if (rst_n) begin
         if (tx_start) begin
            if (e_addr.size() == 0) begin
               chk(0, "R3", "unexpected tx_start", 1, 0);
            end else begin
               int ea, ec, el;
               logic [CHUNK*8-1:0] ew;
               ea = e_addr.pop_front(); ec = e_cmd.pop_front();
               el = e_lm1.pop_front();  ew = e_wd.pop_front();
               chk({tx_addr_hi, tx_addr_mid, tx_addr_lo} == 20'(ea), "R2", "address",
                   int'({tx_addr_hi, tx_addr_mid, tx_addr_lo}), ea);
               chk(tx_cmd == 4'(ec), "R4", "command", int'(tx_cmd), ec);
               chk(tx_len_m1 == CW'(el), "R1", "length field", int'(tx_len_m1), el);
               if (ec == 8)
                  chk(tx_wdata == ew, "R5", "write lanes", int'(tx_wdata[31:0]), int'(ew[31:0]));
            end
            r_addr = int'({tx_addr_hi, tx_addr_mid, tx_addr_lo});
            r_lm1 = int'(tx_len_m1);
            r_rd = (tx_cmd == 4'b1001);
            r_mode = (rsp_q.size() > 0) ? rsp_q.pop_front() : 0;
            tx_pend = 1'b1; r_cnt = 0; r_k = 0; r_act = 1;
         end else if (r_act) begin
            r_cnt++;
            if (r_mode != 1 && r_cnt == 3) tx_pend = 1'b0;
            if (!tx_pend && r_rd && r_cnt >= 4 && r_k <= r_lm1) begin
               tx_rd_we = 1'b1;
               tx_rd_idx = CW'(r_k);
               tx_rd_data = (r_mode == 0) ? rb(r_addr + r_k) : ~rb(r_addr + r_k);
               r_k++;
            end
            if (r_cnt == 25 && r_mode != 1 && r_mode != 2) begin
               tx_reply = 1'b1;
               tx_rerr = (r_mode == 3);
               tx_rstat = (r_mode == 4) ? 4'h5 : 4'h0;
               r_act = 0;
            end
         end
         if (cb_wr_en) begin
            if (e_idx.size() == 0) begin
               chk(0, "R7", "unexpected caller store", int'(cb_idx), -1);
            end else begin
               int ei, ed;
               ei = e_idx.pop_front(); ed = e_dat.pop_front();
               chk(cb_idx == LEN_W'(ei), "R7", "store index", int'(cb_idx), ei);
               chk(cb_wdata == 8'(ed), "R7", "store data", int'(cb_wdata), ed);
            end
         end
         if (done) begin
            done_seen = 1;
            chk(done_err == exp_err, "R9", "done_err", int'(done_err), int'(exp_err));
            chk(e_addr.size() == 0, "R3", "starts left", e_addr.size(), 0);
            chk(e_idx.size() == 0, "R7", "stores left", e_idx.size(), 0);
         end
      end
   end

   task automatic run(input bit w, input int addr, input int len);
      int rem, a, p, si;
      rem = len; a = addr; p = 0; si = 0; exp_err = 0;
      while (rem > 0) begin
         int cl;
         bit ok;
         cl = (rem > CHUNK) ? CHUNK : rem;
         ok = 0;
         for (int t = 0; t < 10; t++) begin
            int m;
            logic [CHUNK*8-1:0] wd;
            m = (si < script.size()) ? script[si] : 0;
            si++;
            wd = '0;
            if (w) for (int q = 0; q < cl; q++) wd[q*8 +: 8] = 8'((p + q) * 13 + 5);
            e_addr.push_back(a & 32'hFFFFF); e_cmd.push_back(w ? 8 : 9);
            e_lm1.push_back(cl - 1); e_wd.push_back(wd);
            if (m == 0) begin ok = 1; break; end
         end
         if (!ok) begin exp_err = 1; break; end
         if (!w) for (int q = 0; q < cl; q++) begin
            e_idx.push_back(p + q); e_dat.push_back(int'(rb(a + q)));
         end
         a += cl; p += cl; rem -= cl;
      end
      rsp_q = script;
      done_seen = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = 20'(addr); req_len = LEN_W'(len);
      @(negedge clk);
      req_valid = 1'b0;
      if (len == 0) begin
         chk(done === 1'b1 && done_err === 1'b0, "R8", "zero-length done", int'(done), 1);
         chk(e_addr.size() == 0, "R8", "no start", e_addr.size(), 0);
      end
      while (!done_seen) @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R9", "idle after done", int'(busy), 0);
      script.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && tx_start == 1'b0, "R9", "reset state",
          int'({busy, done, tx_start}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R8: zero length
      run(1'b0, 20'h00100, 0);
      // R1 R4 R5: short write
      run(1'b1, 20'h12345, 5);
      // R1 R2: multi-chunk read across a 64 KiB boundary
      run(1'b0, 20'h0FFF8, 40);
      // R5: short write after full read, upper lanes must be clear
      run(1'b1, 20'h00200, 3);
      // R1: exactly one full chunk
      run(1'b0, 20'h00300, 16);
      // R6 R7: each failure kind then success, second chunk clean
      script = '{1, 2, 3, 4, 0, 0};
      run(1'b0, 20'h00400, 20);
      // R10: each chunk succeeds on its tenth attempt
      script = '{1, 2, 3, 4, 3, 3, 3, 3, 4, 0, 4, 4, 3, 3, 2, 3, 3, 3, 3, 0};
      run(1'b1, 20'h00500, 18);
      // R3: all ten attempts fail, request aborts
      script = '{3, 3, 3, 3, 3, 3, 3, 3, 3, 3};
      run(1'b0, 20'h00600, 20);
      // R9: clean request after an aborted one
      run(1'b0, 20'h00700, 2);
      summary();
      $finish;
   end
endmodule